// File: doc/BRIEF.md
# Supply Voltage Monitor Controller

This block is the digital half of a low-voltage detector. An analog front end compares the supply against reference levels and hands over three digital comparator results: supply at or above a high threshold, at or above a low threshold, and at or above a single threshold. The controller turns these into an internal reset request, a one-clock interrupt request, a detection-status flag and a sticky flag recording that the detector caused a reset. It also forwards a level-select code to the reference ladder.

A 2-bit mode field and a 4-bit level code are captured while the system reset input is low. The mode picks how the thresholds are used: a dual-threshold hysteretic mode that warns first and resets later, a reset-only mode on one threshold, and an interrupt-only mode. In the interrupt-only mode, reset is still held after any reset until the supply first comes up. Timing rests only on the clock, so the block keeps working from an always-on clock while the rest of the system is in its low-power stop state.

Top module: `supply_mon_ctrl`

## Requirements
- R1: The mode field is captured while `rst_n` is low. Code 2'b10 selects dual-threshold mode, 2'b11 reset-only mode and 2'b01 interrupt-only mode. Code 2'b00 turns the detector off: `reset_req`, `irq` and `det_flag` all stay 0.
- R2: In dual-threshold mode, `irq` pulses once when the synchronised high-threshold result goes from 1 to 0. There is no pulse in any other case.
- R3: In dual-threshold mode, `reset_req` is raised when the supply is below the low threshold. Once raised, it is released only when the supply is at or above the high threshold. It is also 1 from reset until that release.
- R4: In reset-only mode, `reset_req` equals the inverse of the synchronised single-threshold result, and `irq` never pulses.
- R5: In interrupt-only mode, `reset_req` is 1 from reset until the single-threshold result first reads 1.
- R6: In interrupt-only mode, after that release, `irq` pulses on every rising and every falling crossing of the single threshold, and `reset_req` never rises again. The release itself gives no pulse.
- R7: `det_flag` is 1 when the supply is below the active level. That level is the high threshold in dual-threshold mode and the single threshold in the other two active modes.
- R8: `cause_flag` is set when the detector raises `reset_req` from 0 to 1. Holding reset from the moment `rst_n` releases does not set it.
- R9: `cause_flag` is unaffected by `rst_n`. It clears on a one-cycle `cause_clr` pulse or on `por_n` low. A set in the same cycle wins over a clear.
- R10: `level_sel` is the level code captured during reset. Codes 0 to 13 pass unchanged, and codes 14 and 15 are limited to 13, giving 14 levels.
- R11: Each comparator input passes two synchroniser flops. A change made before clock edge k shows on `reset_req`, `det_flag` and `irq` after edge k+2, and `irq` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, clears the cause flag |
| rst_n | input | 1 | System reset, active low, captures mode and level |
| mode_opt | input | 2 | Mode code from nonvolatile options |
| level_opt | input | 4 | Level code from nonvolatile options |
| cmp_hi | input | 1 | Supply at or above high threshold (asynchronous) |
| cmp_lo | input | 1 | Supply at or above low threshold (asynchronous) |
| cmp_single | input | 1 | Supply at or above single threshold (asynchronous) |
| cause_clr | input | 1 | Write-one clear of the cause flag |
| level_sel | output | 4 | Level code to the reference ladder |
| reset_req | output | 1 | Internal reset request |
| irq | output | 1 | One-cycle interrupt request |
| det_flag | output | 1 | Supply below active level |
| cause_flag | output | 1 | Sticky detector reset cause |

## Verification
The assertions assume the comparator results are physically consistent: when the high-threshold result is 1, the low one is 1 too. They also assume `cause_clr` is a single-cycle write strobe. The stimulus drives the comparators from one supply value with three steps (below both, between, above both), so the high and low results can never disagree. Each step is held for several clocks, well beyond the synchroniser delay. The sweep runs every ordered pair of supply steps in each mode after a fresh reset.

// File: rtl/supply_mon_ctrl.sv
module supply_mon_ctrl #(
  parameter int LVL_W   = 4,
  parameter int LVL_MAX = 13
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic [1:0]       mode_opt,
  input  logic [LVL_W-1:0] level_opt,
  input  logic             cmp_hi,
  input  logic             cmp_lo,
  input  logic             cmp_single,
  input  logic             cause_clr,
  output logic [LVL_W-1:0] level_sel,
  output logic             reset_req,
  output logic             irq,
  output logic             det_flag,
  output logic             cause_flag
);
  localparam logic [1:0] M_OFF   = 2'b00;
  localparam logic [1:0] M_IONLY = 2'b01;
  localparam logic [1:0] M_DUAL  = 2'b10;
  localparam logic [1:0] M_RONLY = 2'b11;
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(LVL_MAX);

  logic [1:0]       mode_q;
  logic [LVL_W-1:0] lvl_q;
  logic [2:0]       sy1, sy2, prv;
  logic             rst_q, irq_q, det_q, cause_q;
  logic             rst_d, irq_d, det_d, set_evt;

  always_ff @(posedge clk)
    if (!rst_n) begin
      mode_q <= mode_opt;
      lvl_q  <= (level_opt > LVL_TOP) ? LVL_TOP : level_opt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
    end else begin
      sy1 <= {cmp_single, cmp_lo, cmp_hi};
      sy2 <= sy1;
      prv <= sy2;
    end

  wire s_hi  = sy2[0];
  wire s_lo  = sy2[1];
  wire s_sgl = sy2[2];
  wire p_hi  = prv[0];
  wire p_sgl = prv[2];
  wire en    = mode_q != M_OFF;

  always_comb begin
    rst_d = rst_q;
    irq_d = 1'b0;
    det_d = 1'b0;
    case (mode_q)
      M_DUAL: begin
        rst_d = ~s_lo | (rst_q & ~s_hi);
        irq_d = p_hi & ~s_hi;
        det_d = ~s_hi;
      end
      M_RONLY: begin
        rst_d = ~s_sgl;
        det_d = ~s_sgl;
      end
      M_IONLY: begin
        rst_d = rst_q & ~s_sgl;
        irq_d = ~rst_q & (s_sgl ^ p_sgl);
        det_d = ~s_sgl;
      end
      default: ;
    endcase
  end

  assign set_evt = en & rst_d & ~rst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q <= 1'b1;
      irq_q <= 1'b0;
      det_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      irq_q <= irq_d;
      det_q <= det_d;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) cause_q <= 1'b0;
    else        cause_q <= set_evt | (cause_q & ~cause_clr);

  assign level_sel  = lvl_q;
  assign reset_req  = rst_q & en;
  assign irq        = irq_q;
  assign det_flag   = det_q;
  assign cause_flag = cause_q;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |-> (!reset_req && !irq && !det_flag)); // R1
  AST_DUAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_DUAL) && $fell(reset_req)) |-> $past(s_hi)); // R3
  AST_RONLY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RONLY) |-> !irq); // R4
  AST_IONLY_NO_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_IONLY) && !reset_req) |=> !reset_req); // R6
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (cause_flag && !cause_clr) |=> cause_flag); // R9
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_sel <= LVL_TOP); // R10
endmodule

// File: tb/supply_mon_ctrl_tb.sv
module supply_mon_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n, rst_n, cmp_hi, cmp_lo, cmp_single, cause_clr;
  logic [1:0] mode_opt;
  logic [3:0] level_opt, level_sel;
  logic reset_req, irq, det_flag, cause_flag;

  supply_mon_ctrl dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .mode_opt(mode_opt),
    .level_opt(level_opt), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .cmp_single(cmp_single), .cause_clr(cause_clr), .level_sel(level_sel),
    .reset_req(reset_req), .irq(irq), .det_flag(det_flag),
    .cause_flag(cause_flag));

  int checks = 0, fails = 0;
  int m_mode = 0, pv = 0;
  bit m_rst = 1'b1, m_cause = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_v(int v);
    cmp_hi = (v == 2); cmp_lo = (v >= 1); cmp_single = (v >= 1);
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    m_cause = 1'b0;
    chk("R9 por clears cause", cause_flag, 0);
  endtask

  task automatic do_rst(int mode, int lvl);
    @(negedge clk);
    set_v(0); pv = 0;
    mode_opt = mode[1:0]; level_opt = lvl[3:0]; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_mode = mode; m_rst = 1'b1;
    chk(mode == 0 ? "R1 off after reset" : "R5 reset held after reset",
        reset_req, (mode != 0) ? 1 : 0);
  endtask

  task automatic apply(int v);
    int n, pos, exp_irq, exp_det;
    bit old_rst;
    string tg;
    @(negedge clk);
    set_v(v);
    old_rst = m_rst; exp_irq = 0; exp_det = 0;
    case (m_mode)
      2: begin
        exp_irq = (pv == 2 && v != 2) ? 1 : 0;
        if (v == 0) m_rst = 1'b1; else if (v == 2) m_rst = 1'b0;
        exp_det = (v != 2) ? 1 : 0;
      end
      3: begin m_rst = (v == 0); exp_det = (v == 0) ? 1 : 0; end
      1: begin
        exp_irq = (!m_rst && ((pv >= 1) != (v >= 1))) ? 1 : 0;
        if (m_rst && v >= 1) m_rst = 1'b0;
        exp_det = (v == 0) ? 1 : 0;
      end
      default: ;
    endcase
    if (m_mode != 0 && m_rst && !old_rst) m_cause = 1'b1;
    pv = v;
    n = 0; pos = -1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq) begin n++; if (pos < 0) pos = i; end
    end
    tg = (m_mode == 2) ? "R2 dual irq" : (m_mode == 1) ? "R6 ionly irq" :
         (m_mode == 3) ? "R4 ronly irq" : "R1 off irq";
    chk(tg, n, exp_irq);
    if (exp_irq != 0) chk("R11 irq on third edge", pos, 2);
    tg = (m_mode == 2) ? "R3 dual reset" : (m_mode == 1) ? "R5 ionly reset" :
         (m_mode == 3) ? "R4 ronly reset" : "R1 off reset";
    chk(tg, reset_req, (m_mode != 0 && m_rst) ? 1 : 0);
    chk("R7 det flag", det_flag, exp_det);
    chk("R8 cause flag", cause_flag, m_cause);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; cause_clr = 1'b0;
    mode_opt = 2'b11; level_opt = 4'd0; set_v(0);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    chk("R9 cause after power-on", cause_flag, 0);

    for (int l = 0; l < 16; l++) begin
      do_rst(3, l);
      chk("R10 level clamp", level_sel, (l > 13) ? 13 : l);
    end

    for (int md = 0; md < 4; md++) begin
      do_por();
      do_rst(md, 5);
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) begin
          apply(a);
          apply(b);
        end
    end

    apply(2); apply(0);
    chk("R8 cause set by reset-only", cause_flag, 1);
    do_rst(3, 5);
    chk("R9 cause survives rst_n", cause_flag, 1);
    @(negedge clk); cause_clr = 1'b1;
    @(negedge clk); cause_clr = 1'b0;
    m_cause = 1'b0;
    chk("R9 write-one clear", cause_flag, 0);
    apply(2); apply(0);
    chk("R8 cause set again", cause_flag, 1);
    do_por();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule